// File: doc/BRIEF.md
# Breakpoint and Watchpoint Comparator Bank

This block holds a set of instruction-breakpoint pairs and a set of data-watchpoint pairs for a small 32-bit core. Each pair has a 32-bit value register and a control register, both reached through an indexed register port. Every register write takes effect at the next clock edge. On each instruction fetch, every breakpoint pair compares the fetch address and privilege level. On each load or store, every watchpoint pair compares the access address, size, direction and privilege.

When a pair fires and the mode bits allow it, the block pulses a debug event one cycle later. The event output names the lowest-numbered firing pair and carries a vector of every pair that fired. The block also records why the event happened in a status register. A read-only identity word reports how many pairs exist and which debug version is built. A breakpoint can be put in inverted mode, so that it fires on any fetch outside its programmed bytes. Software uses this to step one instruction at a time.

The register port uses `reg_addr[6:4]` to pick a group and `reg_addr[3:0]` to pick the pair index. The groups are 0 for breakpoint value, 1 for breakpoint control, 2 for watchpoint value, 3 for watchpoint control, 4 for status and 5 for identity. Reads are combinational.

Top module: `dbgcmp_top`

## Requirements
- R1: After reset, every value, control and status register reads as zero, and `dbg_evt`, `bp_hit` and `wp_hit` are zero.
- R2: A breakpoint matches when value bits [31:2] equal fetch address bits [31:2] and the control lane bit `5 + fetch_addr[1:0]` is set. Value bits [1:0] are ignored.
- R3: Control bit 0 enables a pair. A pair whose control register holds zero never fires.
- R4: Breakpoint control bit 13 inverts the match. An enabled pair with this bit set fires on a fetch that does not hit its selected bytes. Watchpoints do not store this bit.
- R5: Watchpoint control bit 3 allows loads and bit 4 allows stores. With both set, the pair matches either direction.
- R6: A watchpoint compares address bits [31:3] and uses control bits [12:5] as byte lanes 0..7 of a doubleword. It fires when these lanes overlap the bytes of the access. The access covers `1 << acc_size` bytes starting at `acc_addr[2:0]`.
- R7: Control bit 1 allows user-mode accesses (privilege input 0). Control bit 2 allows privileged accesses (privilege input 1).
- R8: The identity word (group 5) is laid out as follows: watchpoint count minus one in [31:28], breakpoint count minus one in [27:24], and the version in [19:16]. All other bits are zero.
- R9: Status bit 0 is halting enable and bit 1 is monitor enable. An event or hit is reported only when monitor is 1 and halting is 0.
- R10: Status bits [4:2] hold the cause of the last event: 1 breakpoint, 2 synchronous watchpoint, 3 watchpoint on a buffered access. A breakpoint wins over a watchpoint in the same cycle, and `evt_wp` is then 0.
- R11: When several pairs fire, `evt_idx` names the lowest-numbered breakpoint, or if none, the lowest watchpoint. `bp_hit`/`wp_hit` show every firing pair.
- R12: The block reports the comparison one cycle after the fetch or access. A register write made in the same cycle as a fetch applies only from the next cycle. Unimplemented control bits read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Group [6:4] and pair index [3:0] |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data |
| fetch_vld | input | 1 | Instruction fetch this cycle |
| fetch_addr | input | 32 | Fetch address |
| fetch_priv | input | 1 | Fetch is privileged |
| acc_vld | input | 1 | Data access this cycle |
| acc_addr | input | 32 | Data access address |
| acc_store | input | 1 | Access is a store |
| acc_size | input | 2 | Log2 of access bytes |
| acc_priv | input | 1 | Access is privileged |
| acc_buffered | input | 1 | Access is reported asynchronously |
| dbg_evt | output | 1 | Debug event pulse |
| evt_wp | output | 1 | Event came from a watchpoint |
| evt_idx | output | 4 | Reported pair index |
| bp_hit | output | NUM_BP | Firing breakpoint pairs |
| wp_hit | output | NUM_WP | Firing watchpoint pairs |

## Verification
The assertions check the following on every cycle:
- An event is only ever reported after a cycle in which monitor mode was on and halting mode was off.
- A reported breakpoint index is the lowest bit set in the hit vector.
- A breakpoint event leaves the breakpoint cause in the status register.
- No disabled pair raises a raw match.

Some behaviours appear only in the bench's directed scenarios, compared against the reference model every cycle:
- byte-lane selection and access-size overlap
- inverted matching
- privilege and direction filtering
- the ordering of a write against a fetch in the same cycle

// File: rtl/dbgcmp_pkg.sv
package dbgcmp_pkg;

    // control register field positions
    localparam int CTL_EN      = 0;
    localparam int CTL_USR     = 1;
    localparam int CTL_PRV     = 2;
    localparam int CTL_LD      = 3;
    localparam int CTL_ST      = 4;
    localparam int CTL_LANE_LO = 5;
    localparam int CTL_MISM    = 13;

    typedef enum logic [2:0] {
        MOE_NONE     = 3'd0,
        MOE_BKPT     = 3'd1,
        MOE_WP_SYNC  = 3'd2,
        MOE_WP_ASYNC = 3'd3
    } moe_e;

    typedef enum logic [2:0] {
        GRP_BVAL = 3'd0,
        GRP_BCTL = 3'd1,
        GRP_WVAL = 3'd2,
        GRP_WCTL = 3'd3,
        GRP_STAT = 3'd4,
        GRP_ID   = 3'd5
    } grp_e;

    typedef struct packed {
        logic       mism;
        logic [3:0] lanes;
        logic       prv;
        logic       usr;
        logic       en;
    } bctl_t;

    typedef struct packed {
        logic [7:0] lanes;
        logic       st;
        logic       ld;
        logic       prv;
        logic       usr;
        logic       en;
    } wctl_t;

endpackage

// File: rtl/dbgcmp_bp_cmp.sv
module dbgcmp_bp_cmp
    import dbgcmp_pkg::*;
(
    input  logic [29:0] tag,
    input  bctl_t       ctl,
    input  logic        fetch_vld,
    input  logic [31:0] fetch_addr,
    input  logic        fetch_priv,
    output logic        hit
);
    logic word_eq;
    logic lane_on;
    logic priv_ok;

    always_comb begin
        word_eq = (tag == fetch_addr[31:2]);
        lane_on = ctl.lanes[fetch_addr[1:0]];
        priv_ok = fetch_priv ? ctl.prv : ctl.usr;
        hit     = fetch_vld & ctl.en & priv_ok & ((word_eq & lane_on) ^ ctl.mism);
    end
endmodule

// File: rtl/dbgcmp_wp_cmp.sv
module dbgcmp_wp_cmp
    import dbgcmp_pkg::*;
#(
    parameter bit  WIDE  = 1'b1,
    localparam int LB    = WIDE ? 3 : 2,
    localparam int LANES = WIDE ? 8 : 4
) (
    input  logic [31-LB:0] tag,
    input  wctl_t          ctl,
    input  logic           acc_vld,
    input  logic [31:0]    acc_addr,
    input  logic           acc_store,
    input  logic [1:0]     acc_size,
    input  logic           acc_priv,
    output logic           hit
);
    logic [15:0]      span_w;
    logic [15:0]      span_sh;
    logic [LANES-1:0] span;
    logic             addr_eq;
    logic             dir_ok;
    logic             priv_ok;

    always_comb begin
        span_w  = (16'd1 << (5'd1 << acc_size)) - 16'd1;
        span_sh = span_w << acc_addr[LB-1:0];
        span    = span_sh[LANES-1:0];
        addr_eq = (tag == acc_addr[31:LB]);
        dir_ok  = acc_store ? ctl.st : ctl.ld;
        priv_ok = acc_priv ? ctl.prv : ctl.usr;
        hit     = acc_vld & ctl.en & dir_ok & priv_ok & addr_eq
                  & (|(span & ctl.lanes[LANES-1:0]));
    end
endmodule

// File: rtl/dbgcmp_pick.sv
module dbgcmp_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/dbgcmp_top.sv
module dbgcmp_top
    import dbgcmp_pkg::*;
#(
    parameter int NUM_BP   = 4,
    parameter int NUM_WP   = 2,
    parameter bit WP_WIDE  = 1'b1,
    parameter int ARCH_VER = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [6:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              fetch_vld,
    input  logic [31:0]       fetch_addr,
    input  logic              fetch_priv,
    input  logic              acc_vld,
    input  logic [31:0]       acc_addr,
    input  logic              acc_store,
    input  logic [1:0]        acc_size,
    input  logic              acc_priv,
    input  logic              acc_buffered,
    output logic              dbg_evt,
    output logic              evt_wp,
    output logic [3:0]        evt_idx,
    output logic [NUM_BP-1:0] bp_hit,
    output logic [NUM_WP-1:0] wp_hit
);
    localparam int BP_IW = (NUM_BP > 1) ? $clog2(NUM_BP) : 1;
    localparam int WP_IW = (NUM_WP > 1) ? $clog2(NUM_WP) : 1;
    localparam int WLB   = WP_WIDE ? 3 : 2;

    typedef struct packed {
        logic [NUM_BP-1:0][31:0] bval;
        bctl_t [NUM_BP-1:0]      bctl;
        logic [NUM_WP-1:0][31:0] wval;
        wctl_t [NUM_WP-1:0]      wctl;
        logic                    halt;
        logic                    mon;
        moe_e                    moe;
        logic                    evt;
        logic                    evt_wp;
        logic [3:0]              evt_idx;
        logic [NUM_BP-1:0]       bp_hit;
        logic [NUM_WP-1:0]       wp_hit;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_BP-1:0] bp_raw, bp_fire;
    logic [NUM_WP-1:0] wp_raw, wp_fire;
    logic              bp_any, wp_any;
    logic [BP_IW-1:0]  bp_idx;
    logic [WP_IW-1:0]  wp_idx;
    logic              gate;
    logic [2:0]        grp;
    logic [3:0]        ridx;

    // comparator instances
    for (genvar g = 0; g < NUM_BP; g++) begin : g_bp
        dbgcmp_bp_cmp u_cmp (
            .tag        (st_q.bval[g][31:2]),
            .ctl        (st_q.bctl[g]),
            .fetch_vld  (fetch_vld),
            .fetch_addr (fetch_addr),
            .fetch_priv (fetch_priv),
            .hit        (bp_raw[g])
        );
        // R3
        bp_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
            bp_raw[g] |-> st_q.bctl[g].en);
    end

    for (genvar g = 0; g < NUM_WP; g++) begin : g_wp
        dbgcmp_wp_cmp #(.WIDE(WP_WIDE)) u_cmp (
            .tag       (st_q.wval[g][31:WLB]),
            .ctl       (st_q.wctl[g]),
            .acc_vld   (acc_vld),
            .acc_addr  (acc_addr),
            .acc_store (acc_store),
            .acc_size  (acc_size),
            .acc_priv  (acc_priv),
            .hit       (wp_raw[g])
        );
    end

    always_comb begin
        gate    = st_q.mon & ~st_q.halt;
        bp_fire = bp_raw & {NUM_BP{gate}};
        wp_fire = wp_raw & {NUM_WP{gate}};
    end

    dbgcmp_pick #(.N(NUM_BP), .IW(BP_IW)) u_bp_pick (.req(bp_fire), .any(bp_any), .idx(bp_idx));
    dbgcmp_pick #(.N(NUM_WP), .IW(WP_IW)) u_wp_pick (.req(wp_fire), .any(wp_any), .idx(wp_idx));

    // next-state
    always_comb begin
        st_d         = st_q;
        grp          = reg_addr[6:4];
        ridx         = reg_addr[3:0];
        st_d.bp_hit  = bp_fire;
        st_d.wp_hit  = wp_fire;
        st_d.evt     = bp_any | wp_any;
        st_d.evt_wp  = ~bp_any & wp_any;
        if (bp_any)      st_d.evt_idx = 4'(bp_idx);
        else if (wp_any) st_d.evt_idx = 4'(wp_idx);
        else             st_d.evt_idx = 4'd0;

        if (bp_any)      st_d.moe = MOE_BKPT;
        else if (wp_any) st_d.moe = acc_buffered ? MOE_WP_ASYNC : MOE_WP_SYNC;

        if (reg_we) begin
            case (grp)
                GRP_BVAL: for (int i = 0; i < NUM_BP; i++)
                    if (ridx == 4'(i)) st_d.bval[i] = reg_wdata;
                GRP_BCTL: for (int i = 0; i < NUM_BP; i++)
                    if (ridx == 4'(i)) begin
                        st_d.bctl[i].en    = reg_wdata[CTL_EN];
                        st_d.bctl[i].usr   = reg_wdata[CTL_USR];
                        st_d.bctl[i].prv   = reg_wdata[CTL_PRV];
                        st_d.bctl[i].lanes = reg_wdata[CTL_LANE_LO +: 4];
                        st_d.bctl[i].mism  = reg_wdata[CTL_MISM];
                    end
                GRP_WVAL: for (int i = 0; i < NUM_WP; i++)
                    if (ridx == 4'(i)) st_d.wval[i] = reg_wdata;
                GRP_WCTL: for (int i = 0; i < NUM_WP; i++)
                    if (ridx == 4'(i)) begin
                        st_d.wctl[i].en    = reg_wdata[CTL_EN];
                        st_d.wctl[i].usr   = reg_wdata[CTL_USR];
                        st_d.wctl[i].prv   = reg_wdata[CTL_PRV];
                        st_d.wctl[i].ld    = reg_wdata[CTL_LD];
                        st_d.wctl[i].st    = reg_wdata[CTL_ST];
                        st_d.wctl[i].lanes = WP_WIDE ? reg_wdata[CTL_LANE_LO +: 8]
                                                     : {4'b0, reg_wdata[CTL_LANE_LO +: 4]};
                    end
                GRP_STAT: begin
                    st_d.halt = reg_wdata[0];
                    st_d.mon  = reg_wdata[1];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_addr[6:4])
            GRP_BVAL: for (int i = 0; i < NUM_BP; i++)
                if (reg_addr[3:0] == 4'(i)) reg_rdata = st_q.bval[i];
            GRP_BCTL: for (int i = 0; i < NUM_BP; i++)
                if (reg_addr[3:0] == 4'(i))
                    reg_rdata = {18'b0, st_q.bctl[i].mism, 4'b0, st_q.bctl[i].lanes,
                                 2'b0, st_q.bctl[i].prv, st_q.bctl[i].usr, st_q.bctl[i].en};
            GRP_WVAL: for (int i = 0; i < NUM_WP; i++)
                if (reg_addr[3:0] == 4'(i)) reg_rdata = st_q.wval[i];
            GRP_WCTL: for (int i = 0; i < NUM_WP; i++)
                if (reg_addr[3:0] == 4'(i))
                    reg_rdata = {19'b0, st_q.wctl[i].lanes, st_q.wctl[i].st, st_q.wctl[i].ld,
                                 st_q.wctl[i].prv, st_q.wctl[i].usr, st_q.wctl[i].en};
            GRP_STAT: reg_rdata = {27'b0, st_q.moe, st_q.mon, st_q.halt};
            GRP_ID:   reg_rdata = {4'(NUM_WP - 1), 4'(NUM_BP - 1), 4'b0, 4'(ARCH_VER), 16'b0};
            default:  reg_rdata = '0;
        endcase
    end

    assign dbg_evt = st_q.evt;
    assign evt_wp  = st_q.evt_wp;
    assign evt_idx = st_q.evt_idx;
    assign bp_hit  = st_q.bp_hit;
    assign wp_hit  = st_q.wp_hit;

    // R9
    gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_evt |-> $past(st_q.mon && !st_q.halt));

    // R11
    lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_evt && !evt_wp) |-> (((bp_hit >> evt_idx) & NUM_BP'(1)) != '0)
                              && ((bp_hit & ((NUM_BP'(1) << evt_idx) - NUM_BP'(1))) == '0));

    // R10
    moe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_evt && !evt_wp) |-> (st_q.moe == MOE_BKPT));

    // R11
    hitvec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_evt && evt_wp) |-> (bp_hit == '0) && (wp_hit != '0));

endmodule

// File: tb/dbgcmp_top_bench.sv
module dbgcmp_top_bench;
    localparam int NBP = 4;
    localparam int NWP = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_we = 1'b0;
    logic [6:0]      reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic            fetch_vld = 1'b0;
    logic [31:0]     fetch_addr = '0;
    logic            fetch_priv = 1'b0;
    logic            acc_vld = 1'b0;
    logic [31:0]     acc_addr = '0;
    logic            acc_store = 1'b0;
    logic [1:0]      acc_size = '0;
    logic            acc_priv = 1'b0;
    logic            acc_buffered = 1'b0;
    logic            dbg_evt, evt_wp;
    logic [3:0]      evt_idx;
    logic [NBP-1:0]  bp_hit;
    logic [NWP-1:0]  wp_hit;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    dbgcmp_top u_dbgcmp_top (
        .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
        .fetch_vld, .fetch_addr, .fetch_priv,
        .acc_vld, .acc_addr, .acc_store, .acc_size, .acc_priv, .acc_buffered,
        .dbg_evt, .evt_wp, .evt_idx, .bp_hit, .wp_hit
    );

    // reference model state
    logic [31:0] m_bval [NBP];
    logic [31:0] m_bctl [NBP];
    logic [31:0] m_wval [NWP];
    logic [31:0] m_wctl [NWP];
    int m_halt = 0, m_mon = 0, m_moe = 0;
    int e_evt = 0, e_wp = 0, e_idx = 0, e_bph = 0, e_wph = 0;

    function automatic logic [31:0] m_read(logic [6:0] a);
        int g = int'(a[6:4]);
        int i = int'(a[3:0]);
        case (g)
            0: return (i < NBP) ? m_bval[i] : 32'h0;
            1: return (i < NBP) ? m_bctl[i] : 32'h0;
            2: return (i < NWP) ? m_wval[i] : 32'h0;
            3: return (i < NWP) ? m_wctl[i] : 32'h0;
            4: return 32'(m_halt | (m_mon << 1) | (m_moe << 2));
            5: return 32'h1305_0000;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // one clock: predict, apply write, step, compare
    task automatic cyc(string tag);
        int gate = (m_mon == 1 && m_halt == 0) ? 1 : 0;
        int bph = 0, wph = 0;
        for (int i = 0; i < NBP; i++) begin
            logic [31:0] c = m_bctl[i];
            int pok  = fetch_priv ? int'(c[2]) : int'(c[1]);
            int lane = int'(c[5 + int'(fetch_addr[1:0])]);
            int wm   = (m_bval[i][31:2] == fetch_addr[31:2] && lane == 1) ? 1 : 0;
            if (fetch_vld && c[0] && pok == 1 && (wm != int'(c[13])) && gate == 1)
                bph |= (1 << i);
        end
        for (int i = 0; i < NWP; i++) begin
            logic [31:0] c = m_wctl[i];
            int span = ((1 << (1 << acc_size)) - 1) << acc_addr[2:0];
            int pok  = acc_priv ? int'(c[2]) : int'(c[1]);
            int dok  = acc_store ? int'(c[4]) : int'(c[3]);
            int ovl  = int'(c[12:5]) & span & 8'hFF;
            if (acc_vld && c[0] && pok == 1 && dok == 1 && ovl != 0
                && m_wval[i][31:3] == acc_addr[31:3] && gate == 1)
                wph |= (1 << i);
        end
        e_bph = bph; e_wph = wph;
        e_evt = (bph != 0 || wph != 0) ? 1 : 0;
        e_wp  = (bph == 0 && wph != 0) ? 1 : 0;
        e_idx = 0;
        if (bph != 0) begin
            for (int i = NBP - 1; i >= 0; i--) if (bph[i]) e_idx = i;
            m_moe = 1;
        end else if (wph != 0) begin
            for (int i = NWP - 1; i >= 0; i--) if (wph[i]) e_idx = i;
            m_moe = acc_buffered ? 3 : 2;
        end
        if (reg_we) begin
            int i = int'(reg_addr[3:0]);
            case (int'(reg_addr[6:4]))
                0: if (i < NBP) m_bval[i] = reg_wdata;
                1: if (i < NBP) m_bctl[i] = reg_wdata & 32'h0000_21E7;
                2: if (i < NWP) m_wval[i] = reg_wdata;
                3: if (i < NWP) m_wctl[i] = reg_wdata & 32'h0000_1FFF;
                4: begin m_halt = int'(reg_wdata[0]); m_mon = int'(reg_wdata[1]); end
                default: ;
            endcase
        end
        @(posedge clk);
        #1;
        chk(tag, "dbg_evt", 32'(dbg_evt), 32'(e_evt));
        chk(tag, "evt_wp", 32'(evt_wp), 32'(e_wp));
        chk(tag, "evt_idx", 32'(evt_idx), 32'(e_idx));
        chk(tag, "bp_hit", 32'(bp_hit), 32'(e_bph));
        chk(tag, "wp_hit", 32'(wp_hit), 32'(e_wph));
        chk(tag, "reg_rdata", reg_rdata, m_read(reg_addr));
    endtask

    task automatic wr(logic [6:0] a, logic [31:0] d, string tag);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        cyc(tag);
        reg_we = 1'b0;
    endtask

    task automatic fetch(logic [31:0] a, logic p, string tag);
        fetch_vld = 1'b1; fetch_addr = a; fetch_priv = p;
        cyc(tag);
        fetch_vld = 1'b0;
    endtask

    task automatic access(logic [31:0] a, logic s, logic [1:0] sz, logic p, logic b, string tag);
        acc_vld = 1'b1; acc_addr = a; acc_store = s; acc_size = sz; acc_priv = p; acc_buffered = b;
        cyc(tag);
        acc_vld = 1'b0; acc_buffered = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < NBP; i++) begin m_bval[i] = '0; m_bctl[i] = '0; end
        for (int i = 0; i < NWP; i++) begin m_wval[i] = '0; m_wctl[i] = '0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: everything reads zero after reset
        for (int g = 0; g < 5; g++)
            for (int i = 0; i < 4; i++) begin
                reg_addr = 7'((g << 4) | i);
                #1 chk("R1", "reset read", reg_rdata, 32'h0);
            end
        chk("R1", "reset event", 32'(dbg_evt), 32'h0);
        cyc("R1");

        // R8: identity word
        reg_addr = 7'h50;
        #1 chk("R8", "id word", reg_rdata, 32'h1305_0000);
        cyc("R8");

        // R9: monitor off -> no event
        wr(7'h00, 32'h0000_1000, "R2");
        wr(7'h10, 32'h0000_01E7, "R2");
        fetch(32'h0000_1000, 1'b0, "R9");
        wr(7'h40, 32'h2, "R9");
        fetch(32'h0000_1000, 1'b0, "R2");
        // R2: single lane
        wr(7'h10, 32'h0000_0027, "R2");
        fetch(32'h0000_1002, 1'b0, "R2");
        fetch(32'h0000_1000, 1'b1, "R2");
        fetch(32'h0000_1004, 1'b0, "R2");
        // R9: halting blocks events
        wr(7'h40, 32'h3, "R9");
        fetch(32'h0000_1000, 1'b0, "R9");
        wr(7'h40, 32'h2, "R9");
        // R3: zero control disables
        wr(7'h10, 32'h0, "R3");
        fetch(32'h0000_1000, 1'b0, "R3");
        wr(7'h10, 32'h0000_01E7, "R3");
        fetch(32'h0000_1000, 1'b0, "R3");
        // R7: user-only pair
        wr(7'h01, 32'h0000_2000, "R7");
        wr(7'h11, 32'h0000_01E3, "R7");
        fetch(32'h0000_2000, 1'b1, "R7");
        fetch(32'h0000_2000, 1'b0, "R7");
        // R4: inverted match
        wr(7'h02, 32'h0000_3000, "R4");
        wr(7'h12, 32'h0000_21E7, "R4");
        fetch(32'h0000_3000, 1'b0, "R4");
        fetch(32'h0000_3004, 1'b0, "R4");
        // R11: pairs 0 and 2 together
        fetch(32'h0000_1000, 1'b0, "R11");
        wr(7'h12, 32'h0, "R4");
        // R12: write and fetch in the same cycle
        wr(7'h03, 32'h0000_4000, "R12");
        fetch_vld = 1'b1; fetch_addr = 32'h0000_4000; fetch_priv = 1'b0;
        wr(7'h13, 32'h0000_01E7, "R12");
        fetch_vld = 1'b0;
        fetch(32'h0000_4000, 1'b0, "R12");
        wr(7'h13, 32'hFFFF_FFFF, "R12");
        chk("R12", "bp ctl mask", reg_rdata, 32'h0000_21E7);
        wr(7'h13, 32'h0, "R12");
        // R5: direction
        wr(7'h20, 32'h0000_8000, "R5");
        wr(7'h30, 32'h0000_1FEF, "R5");
        access(32'h0000_8000, 1'b1, 2'd2, 1'b0, 1'b0, "R5");
        access(32'h0000_8000, 1'b0, 2'd2, 1'b0, 1'b0, "R5");
        reg_addr = 7'h40; #1 chk("R10", "sync cause", reg_rdata, 32'h0000_000A);
        wr(7'h30, 32'hFFFF_FFFF, "R5");
        chk("R12", "wp ctl mask", reg_rdata, 32'h0000_1FFF);
        access(32'h0000_8004, 1'b1, 2'd0, 1'b1, 1'b1, "R5");
        reg_addr = 7'h40; #1 chk("R10", "async cause", reg_rdata, 32'h0000_000E);
        // R6: byte lane 6 only
        wr(7'h21, 32'h0000_9000, "R6");
        wr(7'h31, 32'h0000_081F, "R6");
        access(32'h0000_9004, 1'b0, 2'd2, 1'b0, 1'b0, "R6");
        access(32'h0000_9000, 1'b0, 2'd2, 1'b0, 1'b0, "R6");
        access(32'h0000_9006, 1'b0, 2'd0, 1'b0, 1'b0, "R6");
        access(32'h0000_9007, 1'b0, 2'd0, 1'b0, 1'b0, "R6");
        access(32'h0000_9000, 1'b1, 2'd3, 1'b1, 1'b0, "R6");
        access(32'h0000_9006, 1'b1, 2'd1, 1'b1, 1'b0, "R6");
        // R10: breakpoint wins over watchpoint
        fetch_vld = 1'b1; fetch_addr = 32'h0000_1000; fetch_priv = 1'b0;
        access(32'h0000_8000, 1'b0, 2'd2, 1'b0, 1'b1, "R10");
        fetch_vld = 1'b0;
        chk("R10", "bp cause", 32'(m_moe), 32'd1);
        // R11: both watchpoints
        wr(7'h21, 32'h0000_8000, "R11");
        wr(7'h31, 32'h0000_1FFF, "R11");
        access(32'h0000_8000, 1'b0, 2'd3, 1'b0, 1'b0, "R11");
        reg_addr = 7'h40;
        cyc("R10");
        cyc("R1");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog all-requirements actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule